// File: doc/BRIEF.md
# SPI Register Access Engine

This block is the host side of a register path to an Ethernet MAC-PHY reached over a chunked SPI link. A local client hands it one request: read or write, a 4-bit memory-map selector, a 16-bit register address and, for writes, a 32-bit data word. The engine builds a 32-bit control header, adds an odd-parity bit, and shifts one fixed 96-bit transaction out MSB first in SPI mode 0. Chip select stays low for the whole transaction.

A write sends the header, then the data word, then a zero word. A read sends the header followed by 64 zero bits. The engine drops the first 64 bits it receives, which hold the echoed header, and keeps the last 32 bits as the register value. When chip select rises the engine raises `done` for one cycle. From that point the read value stays stable on `rdata` until the next read completes. The SCLK half-period is a parameter counted in system clocks.

Top module: `ctl_spi_master`

## Requirements
- R1: The header has bit 31 = 0 and bit 30 = 0. The write flag is bit 29 (1 on writes). The address-increment-disable flag is bit 28 (1 on reads, 0 on writes). The map selector sits in bits 27:24, the register address in bits 23:8, and the length field in bits 7:1, which is always zero.
- R2: Header bit 0 is set so that the 32-bit header holds an odd number of ones.
- R3: A write shifts out 96 bits: the header, then the write data, then 32 zero bits.
- R4: A read shifts out the header followed by 64 zero bits. The engine ignores the first 64 received bits and returns the last 32 received bits on `rdata`, MSB first.
- R5: The link runs in SPI mode 0. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low, and MISO is sampled at SCLK rising edges. Each transaction has exactly 96 SCLK rising edges with a half-period of CLK_DIV system clocks. `done` appears 192*CLK_DIV+1 cycles after the cycle in which the request is presented.
- R6: Chip select falls once per accepted request, stays low for the whole transaction, and is high between transactions.
- R7: `busy` is high from the cycle after acceptance until chip select rises. A request presented while `busy` is high is dropped and causes no transaction.
- R8: `done` is a one-cycle pulse in the first cycle in which chip select is high again.
- R9: `rdata` changes only when a read completes. A write leaves it unchanged.
- R10: After reset, chip select is high, SCLK and MOSI are low, and `busy`, `done` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_mms | input | 4 | Memory-map selector |
| req_addr | input | 16 | Register address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read value |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that `miso` changes only while SCLK is low, as a mode-0 device drives it on falling edges. They also assume the client holds a request for a single cycle. The bench's device model shifts its response word on SCLK falling edges and loads the first bit when chip select falls. Every request, including the one deliberately presented mid-transaction, is a one-cycle pulse driven on the falling system-clock edge.

// File: rtl/ctl_spi_pkg.sv
package ctl_spi_pkg;
  localparam int MMS_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int WORD_W    = 32;
  localparam int TXN_WORDS = 3;
  localparam int TXN_BITS  = WORD_W * TXN_WORDS;
  localparam int CNT_W     = $clog2(TXN_BITS + 1);

  localparam int WNR_POS   = 29;
  localparam int AID_POS   = 28;
  localparam int MMS_LSB   = 24;
  localparam int ADDR_LSB  = 8;
  localparam int LEN_LSB   = 1;
  localparam int LEN_W     = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  // returns 1 when v holds an even count of ones
  function automatic logic odd_fill(input logic [WORD_W-2:0] v);
    return ~(^v);
  endfunction

  function automatic logic [WORD_W-1:0] hdr_pack(
    input logic              write,
    input logic [MMS_W-1:0]  mms,
    input logic [ADDR_W-1:0] addr
  );
    logic [WORD_W-1:0] h;
    h = '0;
    h[WNR_POS] = write;
    h[AID_POS] = ~write;
    h[MMS_LSB +: MMS_W] = mms;
    h[ADDR_LSB +: ADDR_W] = addr;
    h[LEN_LSB +: LEN_W] = '0;
    h[0] = odd_fill(h[WORD_W-1:1]);
    return h;
  endfunction
endpackage

// File: rtl/ctl_spi_hdr.sv
module ctl_spi_hdr
  import ctl_spi_pkg::*;
(
  input  logic              write,
  input  logic [MMS_W-1:0]  mms,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] hdr
);
  always_comb hdr = hdr_pack(write, mms, addr);
endmodule

// File: rtl/ctl_spi_clkgen.sv
module ctl_spi_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  assign tick     = run && (div_cnt == DIV_LAST);
  assign rise_stb = tick && !sclk;
  assign fall_stb = tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else begin
      if (!run || tick) div_cnt <= '0;
      else              div_cnt <= div_cnt + 1'b1;
      if (!run)         sclk <= 1'b0;
      else if (tick)    sclk <= ~sclk;
    end
  end
endmodule

// File: rtl/ctl_spi_seq.sv
module ctl_spi_seq
  import ctl_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] hdr,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              miso,
  output logic              accept,
  output logic              xfer,
  output logic              fin,
  output logic              mosi,
  output logic [WORD_W-1:0] rdata
);
  seq_state_t          state;
  logic [TXN_BITS-1:0] tx_sr;
  logic [WORD_W-1:0]   rx_sr;
  logic [CNT_W-1:0]    bit_cnt;
  logic                is_rd;
  logic                last_bit;

  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TXN_BITS);

  assign xfer     = (state == ST_XFER);
  assign fin      = (state == ST_FIN);
  assign accept   = req_valid && !xfer;
  assign last_bit = (bit_cnt == BIT_LAST);
  assign mosi     = xfer && tx_sr[TXN_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_cnt <= '0;
      is_rd   <= 1'b0;
      rdata   <= '0;
    end else begin
      unique case (state)
        ST_XFER: begin
          if (rise_stb) begin
            rx_sr   <= {rx_sr[WORD_W-2:0], miso};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (fall_stb) begin
            if (last_bit) begin
              state <= ST_FIN;
              if (is_rd) rdata <= rx_sr;
            end else begin
              tx_sr <= {tx_sr[TXN_BITS-2:0], 1'b0};
            end
          end
        end
        default: begin
          if (accept) begin
            state   <= ST_XFER;
            tx_sr   <= {hdr, (req_write ? req_wdata : {WORD_W{1'b0}}),
                        {WORD_W{1'b0}}};
            bit_cnt <= '0;
            is_rd   <= !req_write;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ctl_spi_master.sv
module ctl_spi_master
  import ctl_spi_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [MMS_W-1:0]  req_mms,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic [WORD_W-1:0] hdr_w;
  logic              accept_w;
  logic              xfer_w;
  logic              fin_w;
  logic              rise_w;
  logic              fall_w;

  ctl_spi_hdr u_hdr (
    .write (req_write),
    .mms   (req_mms),
    .addr  (req_addr),
    .hdr   (hdr_w)
  );

  ctl_spi_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (xfer_w),
    .sclk     (sclk),
    .rise_stb (rise_w),
    .fall_stb (fall_w)
  );

  ctl_spi_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .hdr       (hdr_w),
    .rise_stb  (rise_w),
    .fall_stb  (fall_w),
    .miso      (miso),
    .accept    (accept_w),
    .xfer      (xfer_w),
    .fin       (fin_w),
    .mosi      (mosi),
    .rdata     (rdata)
  );

  assign busy = xfer_w;
  assign cs_n = !xfer_w;
  assign done = fin_w;
endmodule

// File: rtl/ctl_spi_checker.sv
module ctl_spi_checker
  import ctl_spi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rdata,
  input logic              accept,
  input logic [WORD_W-1:0] hdr
);
  logic [CNT_W:0] rise_cnt;
  logic           sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_HDR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (hdr[31:30] == 2'b00 && hdr[7:1] == '0 && hdr[29] != hdr[28])); // R1
  AST_HDR_ODD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(hdr) % 2 == 1)); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R5
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R5
  AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == (CNT_W+1)'(TXN_BITS))); // R5
  AST_BUSY_CS: assert property (@(posedge clk) disable iff (!rst_n)
    busy != cs_n); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n)); // R8
  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done); // R9
endmodule

bind ctl_spi_master ctl_spi_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .sclk   (sclk),
  .mosi   (mosi),
  .busy   (busy),
  .done   (done),
  .rdata  (rdata),
  .accept (accept_w),
  .hdr    (hdr_w)
);

// File: tb/ctl_spi_master_bench.sv
module ctl_spi_master_bench;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_mms = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, sclk, cs_n, mosi;
  logic        miso = 1'b0;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [95:0] cap;
  logic [95:0] resp;
  logic [95:0] sh;
  int          nrise;
  int          ncs;
  logic [31:0] last_rd;

  always #5 clk = ~clk;

  ctl_spi_master #(.CLK_DIV(DIV)) u_ctl_spi_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mms(req_mms), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  // mode-0 device model
  always @(negedge cs_n) if (rst_n) begin
    ncs = ncs + 1;
    sh = resp;
    miso = sh[95];
  end
  always @(negedge sclk) if (!cs_n) begin
    sh = sh << 1;
    miso = sh[95];
  end
  always @(posedge sclk) if (!cs_n) begin
    cap = {cap[94:0], mosi};
    nrise = nrise + 1;
  end

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input logic wr, input logic [3:0] m,
                                           input logic [15:0] a);
    logic [31:0] h;
    int ones;
    h = 32'd0;
    h[29] = wr;
    h[28] = !wr;
    h[27:24] = m;
    h[23:8] = a;
    ones = 0;
    for (int i = 1; i < 32; i++) ones += h[i];
    h[0] = (ones % 2 == 0);
    return h;
  endfunction

  task automatic run_txn(input logic wr, input logic [3:0] m, input logic [15:0] a,
                         input logic [31:0] wd, input logic [31:0] regv,
                         input bit ign);
    logic [31:0] h;
    logic [95:0] stream;
    int cyc;
    int ones;
    h = exp_hdr(wr, m, a);
    stream = wr ? {h, wd, 32'd0} : {h, 64'd0};
    @(negedge clk);
    resp = {32'hC3C3_1E1E, h, regv};
    nrise = 0; ncs = 0; cap = '0;
    req_valid = 1'b1; req_write = wr; req_mms = m; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (ign && cyc == 20) begin
        req_valid = 1'b1; req_write = !wr; req_mms = ~m; req_addr = ~a;
      end else begin
        req_valid = 1'b0;
      end
    end
    chk("R5 cycles to done", 96'(cyc), 96'(192*DIV+1));
    chk("R5 sclk rises", 96'(nrise), 96'd96);
    chk(wr ? "R3 write stream" : "R4 read stream", cap, stream);
    chk("R1 header fields", {64'd0, cap[95:64] & 32'hFFFF_FFFE},
        {64'd0, 2'b00, wr, !wr, m, a, 8'd0});
    ones = 0;
    for (int i = 64; i < 96; i++) ones += cap[i];
    chk("R2 header odd ones", 96'(ones % 2), 96'd1);
    if (wr) chk("R9 rdata kept on write", {64'd0, rdata}, {64'd0, last_rd});
    else begin
      chk("R4 read data", {64'd0, rdata}, {64'd0, regv});
      last_rd = regv;
    end
    @(negedge clk);
    chk("R8 done one cycle", {95'd0, done}, 96'd0);
    chk("R6 idle cs high sclk low", {94'd0, cs_n, sclk}, {94'd0, 2'b10});
    repeat (3) @(negedge clk);
    chk(ign ? "R7 busy request dropped" : "R6 one cs fall", 96'(ncs), 96'd1);
    chk("R9 rdata stable after done", {64'd0, rdata}, {64'd0, last_rd});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    last_rd = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {59'd0, cs_n, sclk, mosi, busy, done, rdata},
        {59'd0, 1'b1, 4'b0000, 32'd0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {59'd0, cs_n, sclk, mosi, busy, done, rdata},
        {59'd0, 1'b1, 4'b0000, 32'd0});
    for (int m = 0; m < 16; m++) begin
      for (int w = 0; w < 2; w++) begin
        run_txn(w[0], m[3:0], 16'(16'h0F37 * m) ^ (16'h1 << m),
                32'hA5000000 | 32'(m * 32'h01010101 + w),
                {16'(m * 16'h1111), 8'(w), 8'h5A}, 1'b0);
      end
    end
    run_txn(1'b0, 4'h0, 16'h0000, 32'd0, 32'hFFFF_FFFF, 1'b0);
    run_txn(1'b1, 4'hF, 16'hFFFF, 32'hFFFF_FFFF, 32'd0, 1'b0);
    run_txn(1'b0, 4'hF, 16'hFFFF, 32'd0, 32'h8000_0001, 1'b0);
    run_txn(1'b1, 4'h0, 16'h0000, 32'h0000_0001, 32'd0, 1'b0);
    run_txn(1'b0, 4'h3, 16'h1234, 32'd0, 32'hDEAD_BEEF, 1'b1);
    run_txn(1'b1, 4'hA, 16'h00FF, 32'h1357_9BDF, 32'd0, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule